// File: doc/BRIEF.md
# Full-Search Block-Matching SAD Engine

This block performs exhaustive motion estimation for one 16x16 block of 8-bit pixels. The block is matched against a 31x31 pixel search area taken from the previous frame. The two areas share a common centre. The engine scores each of the 256 pixel-shifted placements of the block inside the area with a sum of absolute differences. It then reports the placement with the lowest score as a signed displacement, together with that score.

The host sees only a word-addressed memory of 512 words of 32 bits, through a single port with one cycle of read latency. The host works in four steps:

1. It stores the block and the search area in that memory.
2. It writes a start bit to a control word.
3. It polls the control word until the done bit is set.
4. It reads the packed result word.

Internally the engine first copies the operands into a local pixel store. It then scores one block row (16 pixels) per cycle.

Top module: `sad_me_engine`

## Requirements
- R1: A host write to any word other than 305 and 306 is returned by a host read of that word, with read data valid one cycle after the address is presented.
- R2: Block pixel (row r, column c) is byte ((r*16+c) mod 4) of word (r*16+c)/4, with byte 0 in bits 7:0. Window pixel (row r, column c), with p = r*31+c, is byte (p mod 4) of word 64 + p/4.
- R3: Every top-left placement (py, px) with 0 <= py, px <= 15 is scored. The reported displacement is x = px-8 and y = py-8, and the reported SAD is the minimum score.
- R4: Result word 306 carries x as 5-bit two's complement in bits 4:0, y in bits 12:8 and the SAD in bits 31:16, with all other bits zero.
- R5: When several placements share the minimum score, the first one in row-by-row order (smaller py first, then smaller px) is reported.
- R6: Control word 305 reads busy in bit 0 and done in bit 1, and all other bits read zero. A host write to word 305 with bit 0 set while idle starts a run: done clears and busy reads 1 on the following read.
- R7: For a read issued k cycles after the start write, the control word reads busy for k < 4402 and reads done (value 2) for k >= 4402.
- R8: A start write while busy has no effect on the running search, its timing or its result.
- R9: A write to word 305 with bit 0 clear has no effect, and a host write to word 306 does not alter the result.
- R10: After reset the control word and the result word read zero.
- R11: The largest possible score, 65280, is reported without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write enable |
| host_addr | input | 9 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the address |

## Verification
The search is run with four kinds of data:

- A random window that contains an exact copy of the block at an interior offset. This distinguishes correct byte and word packing from a swapped or shifted layout.
- A uniform image in which every placement ties. This isolates the tie-break order.
- An all-white block against a black window. This reaches the largest score and catches truncation of the SAD field.
- A copy placed at the bottom-right corner with a one-count error. This exercises the last candidate and a nonzero minimum, and it also carries a restart attempt in mid-run.

The control word is compared against a reference count on every cycle of each run, so an early, late or restarted completion is caught.

// File: rtl/sad_pkg.sv
// Shared constants and types for the SAD motion-estimation engine.
// Assumes 8-bit pixels packed four per 32-bit word.
package sad_pkg;
    localparam int BLK        = 16;                    // block edge in pixels
    localparam int SRCH       = 31;                    // search-window edge in pixels
    localparam int RANGE      = SRCH - BLK + 1;        // placements per axis
    localparam int N_CAND     = RANGE * RANGE;
    localparam int PIX_W      = 8;
    localparam int DW         = 32;
    localparam int PPW        = DW / PIX_W;            // pixels per word
    localparam int BLK_PIX    = BLK * BLK;
    localparam int WIN_PIX    = SRCH * SRCH;
    localparam int BLK_WORDS  = BLK_PIX / PPW;
    localparam int WIN_BASE   = BLK_WORDS;
    localparam int WIN_WORDS  = (WIN_PIX + PPW - 1) / PPW;
    localparam int LOAD_WORDS = WIN_BASE + WIN_WORDS;  // operand words copied per run
    localparam int CTRL_ADDR  = LOAD_WORDS;            // control/status word
    localparam int RES_ADDR   = LOAD_WORDS + 1;        // result word
    localparam int MEM_DEPTH  = 512;
    localparam int AW         = $clog2(MEM_DEPTH);
    localparam int SAD_W      = 16;
    localparam int OFF_W      = 5;
    localparam int CENTRE     = RANGE / 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CALC
    } seq_state_t;
endpackage

// File: rtl/sad_word_mem.sv
// Word memory shared by host and engine.
// One host read/write port and one engine read-only port, both with one
// cycle of registered read latency. Reads return the contents from before
// a same-cycle write.
module sad_word_mem #(
    parameter int DEPTH = sad_pkg::MEM_DEPTH,
    parameter int AW    = sad_pkg::AW,
    parameter int DW    = sad_pkg::DW
) (
    input  logic          clk,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic [AW-1:0] e_addr,
    output logic [DW-1:0] e_rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Host write and both registered reads.
    always_ff @(posedge clk) begin
        if (h_we) begin
            mem[h_addr] <= h_wdata;
        end
        h_rdata <= mem[h_addr];
        e_rdata <= mem[e_addr];
    end
endmodule

// File: rtl/sad_pixel_store.sv
// Local pixel copy of the block and the search window.
// Captures packed words addressed in the shared-memory layout. It presents
// one block row and the matching window row segment for a given candidate
// placement. Words at or beyond the window end are never captured.
module sad_pixel_store #(
    parameter int BLK       = sad_pkg::BLK,
    parameter int SRCH      = sad_pkg::SRCH,
    parameter int RANGE     = sad_pkg::RANGE,
    parameter int PIX_W     = sad_pkg::PIX_W,
    parameter int DW        = sad_pkg::DW,
    parameter int AW        = sad_pkg::AW,
    parameter int BLK_WORDS = sad_pkg::BLK_WORDS,
    parameter int WIN_BASE  = sad_pkg::WIN_BASE,
    localparam int PPW      = DW / PIX_W,
    localparam int BLK_PIX  = BLK * BLK,
    localparam int WIN_PIX  = SRCH * SRCH,
    localparam int BIW      = $clog2(BLK_PIX),
    localparam int WIW      = $clog2(WIN_PIX),
    localparam int RW       = $clog2(BLK),
    localparam int CXW      = $clog2(RANGE)
) (
    input  logic             clk,
    input  logic             cap_en,
    input  logic [AW-1:0]    cap_addr,
    input  logic [DW-1:0]    cap_word,
    input  logic [RW-1:0]    row_idx,
    input  logic [CXW-1:0]   cand_y,
    input  logic [CXW-1:0]   cand_x,
    output logic [PIX_W-1:0] blk_row [BLK],
    output logic [PIX_W-1:0] win_row [BLK]
);
    logic [PIX_W-1:0] blk_mem [BLK_PIX];
    logic [PIX_W-1:0] win_mem [WIN_PIX];
    logic [BIW-1:0]   blk_widx [PPW];
    logic [31:0]      win_lin  [PPW];

    // Pixel indices for each byte lane of the word being captured.
    always_comb begin
        for (int b = 0; b < PPW; b++) begin
            blk_widx[b] = BIW'(32'(cap_addr) * PPW + b);
            win_lin[b]  = (32'(cap_addr) - WIN_BASE) * PPW + b;
        end
    end

    // Unpack a captured word into block or window pixels.
    always_ff @(posedge clk) begin
        if (cap_en) begin
            for (int b = 0; b < PPW; b++) begin
                if (32'(cap_addr) < BLK_WORDS) begin
                    blk_mem[blk_widx[b]] <= cap_word[b*PIX_W +: PIX_W];
                end else if (win_lin[b] < WIN_PIX) begin
                    win_mem[win_lin[b][WIW-1:0]] <= cap_word[b*PIX_W +: PIX_W];
                end
            end
        end
    end

    // One lane per block column: block row pixel and displaced window pixel.
    for (genvar l = 0; l < BLK; l++) begin : g_lane
        assign blk_row[l] = blk_mem[BIW'(32'(row_idx) * BLK + l)];
        assign win_row[l] = win_mem[WIW'((32'(cand_y) + 32'(row_idx)) * SRCH
                                         + 32'(cand_x) + l)];
    end
endmodule

// File: rtl/sad_row_diff.sv
// Sum of absolute differences across one row of pixel lanes.
// Purely combinational. The output width holds LANES times the largest
// pixel difference.
module sad_row_diff #(
    parameter int LANES  = sad_pkg::BLK,
    parameter int PIX_W  = sad_pkg::PIX_W,
    localparam int OUT_W = PIX_W + $clog2(LANES)
) (
    input  logic [PIX_W-1:0] a [LANES],
    input  logic [PIX_W-1:0] b [LANES],
    output logic [OUT_W-1:0] sum
);
    logic [PIX_W-1:0] diff [LANES];

    // Per-lane absolute difference.
    for (genvar l = 0; l < LANES; l++) begin : g_abs
        assign diff[l] = (a[l] > b[l]) ? (a[l] - b[l]) : (b[l] - a[l]);
    end

    // Add the lanes together.
    always_comb begin
        sum = '0;
        for (int l = 0; l < LANES; l++) begin
            sum = sum + OUT_W'(diff[l]);
        end
    end
endmodule

// File: rtl/sad_seq.sv
// Run sequencer for the SAD engine.
// Copies the operand words into the pixel store, walks all candidate
// placements row by row, keeps the first minimum in raster order and packs
// the result. Assumes RANGE is a power of two, so that the candidate index
// splits into y and x fields. Start requests while busy are ignored.
module sad_seq #(
    parameter int BLK        = sad_pkg::BLK,
    parameter int RANGE      = sad_pkg::RANGE,
    parameter int PIX_W      = sad_pkg::PIX_W,
    parameter int AW         = sad_pkg::AW,
    parameter int DW         = sad_pkg::DW,
    parameter int LOAD_WORDS = sad_pkg::LOAD_WORDS,
    parameter int SAD_W      = sad_pkg::SAD_W,
    parameter int OFF_W      = sad_pkg::OFF_W,
    localparam int RW        = $clog2(BLK),
    localparam int CXW       = $clog2(RANGE),
    localparam int CW        = 2 * CXW,
    localparam int ROW_W     = PIX_W + RW,
    localparam int CENTRE    = RANGE / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [ROW_W-1:0] row_sad,
    input  logic [DW-1:0]    e_rdata,
    output logic [AW-1:0]    e_addr,
    output logic             cap_en,
    output logic [AW-1:0]    cap_addr,
    output logic [DW-1:0]    cap_word,
    output logic [RW-1:0]    row_idx,
    output logic [CXW-1:0]   cand_y,
    output logic [CXW-1:0]   cand_x,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    result
);
    import sad_pkg::*;

    seq_state_t       state;
    logic [AW-1:0]    ld_cnt;
    logic             rd_v;
    logic [AW-1:0]    rd_a;
    logic [CW-1:0]    cand;
    logic [RW-1:0]    row;
    logic [SAD_W-1:0] acc;
    logic [SAD_W-1:0] best_sad;
    logic [CW-1:0]    best_cand;
    logic [SAD_W-1:0] acc_next;
    logic             take_new;
    logic [SAD_W-1:0] nb_sad;
    logic [CW-1:0]    nb_cand;
    logic [OFF_W-1:0] off_x;
    logic [OFF_W-1:0] off_y;
    logic             row_last;
    logic             cand_last;

    assign e_addr   = ld_cnt;
    assign cap_en   = rd_v;
    assign cap_addr = rd_a;
    assign cap_word = e_rdata;
    assign row_idx  = row;
    assign cand_y   = cand[CW-1:CXW];
    assign cand_x   = cand[CXW-1:0];

    // Candidate score and running-minimum selection (strict less keeps the earliest).
    always_comb begin
        row_last  = (32'(row) == BLK - 1);
        cand_last = (32'(cand) == RANGE * RANGE - 1);
        acc_next  = acc + SAD_W'(row_sad);
        take_new  = (cand == '0) || (acc_next < best_sad);
        nb_sad    = take_new ? acc_next : best_sad;
        nb_cand   = take_new ? cand : best_cand;
        off_x     = OFF_W'(nb_cand[CXW-1:0]) - OFF_W'(CENTRE);
        off_y     = OFF_W'(nb_cand[CW-1:CXW]) - OFF_W'(CENTRE);
    end

    // Run state machine: idle, operand copy, candidate scoring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            busy      <= 1'b0;
            done      <= 1'b0;
            result    <= '0;
            ld_cnt    <= '0;
            rd_v      <= 1'b0;
            rd_a      <= '0;
            cand      <= '0;
            row       <= '0;
            acc       <= '0;
            best_sad  <= '0;
            best_cand <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    rd_v <= 1'b0;
                    if (start_req) begin
                        state  <= ST_LOAD;
                        busy   <= 1'b1;
                        done   <= 1'b0;
                        ld_cnt <= '0;
                    end
                end
                ST_LOAD: begin
                    rd_v <= (32'(ld_cnt) < LOAD_WORDS);
                    rd_a <= ld_cnt;
                    if (32'(ld_cnt) < LOAD_WORDS) begin
                        ld_cnt <= ld_cnt + 1'b1;
                    end else begin
                        state <= ST_CALC;
                        cand  <= '0;
                        row   <= '0;
                        acc   <= '0;
                    end
                end
                ST_CALC: begin
                    if (row_last) begin
                        best_sad  <= nb_sad;
                        best_cand <= nb_cand;
                        acc       <= '0;
                        row       <= '0;
                        if (cand_last) begin
                            state  <= ST_IDLE;
                            busy   <= 1'b0;
                            done   <= 1'b1;
                            result <= {nb_sad, 3'b000, off_y, 3'b000, off_x};
                        end else begin
                            cand <= cand + 1'b1;
                        end
                    end else begin
                        acc <= acc_next;
                        row <= row + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sad_me_engine.sv
// Top level of the full-search SAD motion-estimation engine.
// The host sees one word memory. Word CTRL_ADDR reads {done, busy} and
// starts a run when written with bit 0 set. Word RES_ADDR reads the packed
// result. All other words are plain storage.
module sad_me_engine #(
    parameter int AW = sad_pkg::AW,
    parameter int DW = sad_pkg::DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata
);
    import sad_pkg::*;

    localparam int RW    = $clog2(BLK);
    localparam int CXW   = $clog2(RANGE);
    localparam int ROW_W = PIX_W + RW;

    logic             start_req;
    logic [DW-1:0]    mem_rdata;
    logic [DW-1:0]    e_rdata;
    logic [AW-1:0]    e_addr;
    logic             cap_en;
    logic [AW-1:0]    cap_addr;
    logic [DW-1:0]    cap_word;
    logic [RW-1:0]    row_idx;
    logic [CXW-1:0]   cand_y;
    logic [CXW-1:0]   cand_x;
    logic [PIX_W-1:0] blk_row [BLK];
    logic [PIX_W-1:0] win_row [BLK];
    logic [ROW_W-1:0] row_sad;
    logic             busy_q;
    logic             done_q;
    logic [DW-1:0]    result_q;
    logic             sel_ctrl_q;
    logic             sel_res_q;

    assign start_req = host_we && (32'(host_addr) == CTRL_ADDR) && host_wdata[0];

    sad_word_mem #(.DEPTH(MEM_DEPTH), .AW(AW), .DW(DW)) u_mem (
        .clk(clk), .h_we(host_we), .h_addr(host_addr), .h_wdata(host_wdata),
        .h_rdata(mem_rdata), .e_addr(e_addr), .e_rdata(e_rdata)
    );

    sad_pixel_store #(
        .BLK(BLK), .SRCH(SRCH), .RANGE(RANGE), .PIX_W(PIX_W), .DW(DW), .AW(AW),
        .BLK_WORDS(BLK_WORDS), .WIN_BASE(WIN_BASE)
    ) u_store (
        .clk(clk), .cap_en(cap_en), .cap_addr(cap_addr), .cap_word(cap_word),
        .row_idx(row_idx), .cand_y(cand_y), .cand_x(cand_x),
        .blk_row(blk_row), .win_row(win_row)
    );

    sad_row_diff #(.LANES(BLK), .PIX_W(PIX_W)) u_diff (
        .a(blk_row), .b(win_row), .sum(row_sad)
    );

    sad_seq #(
        .BLK(BLK), .RANGE(RANGE), .PIX_W(PIX_W), .AW(AW), .DW(DW),
        .LOAD_WORDS(LOAD_WORDS), .SAD_W(SAD_W), .OFF_W(OFF_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .row_sad(row_sad),
        .e_rdata(e_rdata), .e_addr(e_addr), .cap_en(cap_en), .cap_addr(cap_addr),
        .cap_word(cap_word), .row_idx(row_idx), .cand_y(cand_y), .cand_x(cand_x),
        .busy(busy_q), .done(done_q), .result(result_q)
    );

    // Remember which register a host read addressed, aligned to memory latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_ctrl_q <= 1'b1;
            sel_res_q  <= 1'b0;
        end else begin
            sel_ctrl_q <= (32'(host_addr) == CTRL_ADDR);
            sel_res_q  <= (32'(host_addr) == RES_ADDR);
        end
    end

    // Host read data: status and result words overlay the memory.
    always_comb begin
        if (sel_ctrl_q) begin
            host_rdata = {{(DW-2){1'b0}}, done_q, busy_q};
        end else if (sel_res_q) begin
            host_rdata = result_q;
        end else begin
            host_rdata = mem_rdata;
        end
    end
endmodule

// File: rtl/sad_me_checker.sv
// Protocol and result-format properties for sad_me_engine, attached by bind.
module sad_me_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_req,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] result
);
    // R6: busy and done are never reported together.
    assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R6: a start while idle arms the engine and clears done.
    assert_start_arms_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req) |=> (busy && !done));

    // R7: done is only raised at the end of a busy run.
    assert_done_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R9: the result word only changes while a run is in progress.
    assert_result_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(result));

    // R3: offsets are within -8..+7 (5-bit sign bit matches bit 3).
    assert_offset_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result[4] == result[3]) && (result[12] == result[11]));

    // R4: padding bits of the result word are zero.
    assert_result_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (result[7:5] == 3'b000) && (result[15:13] == 3'b000));

    // R11: the score never exceeds 256 * 255.
    assert_sad_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        result[31:16] <= 16'd65280);
endmodule

bind sad_me_engine sad_me_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_req(start_req),
    .busy(busy_q), .done(done_q), .result(result_q)
);

// File: tb/sim_sad_me_engine.sv
// Self-checking bench: behavioural search model plus per-cycle status checks.
module sim_sad_me_engine;
    localparam int CTRL = 305;
    localparam int RES  = 306;
    localparam int LAT  = 306 + 256 * 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_we;
    logic [8:0]  host_addr;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          ended = 1'b0;
    int          blk [256];
    int          win [961];
    logic [31:0] exp_res;
    logic [31:0] seed = 32'h1234_5678;
    logic [31:0] v;

    always #2 clk = ~clk;

    sad_me_engine u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[23:16]);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int addr, logic [31:0] data);
        @(negedge clk);
        host_we = 1'b1; host_addr = 9'(addr); host_wdata = data;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(int addr, output logic [31:0] data);
        @(negedge clk);
        host_we = 1'b0; host_addr = 9'(addr);
        @(negedge clk);
        data = host_rdata;
    endtask

    // R2: pack block words 0..63 and window words 64..304, byte 0 lowest.
    task automatic load_mem();
        for (int w = 0; w < 305; w++) begin
            logic [31:0] word;
            word = '0;
            for (int b = 0; b < 4; b++) begin
                int p;
                p = 4 * w + b;
                if (w < 64) word[8*b +: 8] = 8'(blk[p]);
                else if (p - 256 < 961) word[8*b +: 8] = 8'(win[p - 256]);
            end
            wr(w, word);
        end
    endtask

    // R3/R5: exhaustive model, first strict minimum in raster order.
    task automatic model();
        int best, by, bx;
        best = -1; by = 0; bx = 0;
        for (int py = 0; py < 16; py++) begin
            for (int px = 0; px < 16; px++) begin
                int s;
                s = 0;
                for (int r = 0; r < 16; r++) begin
                    for (int c = 0; c < 16; c++) begin
                        int d;
                        d = blk[r*16+c] - win[(py+r)*31 + px + c];
                        s += (d < 0) ? -d : d;
                    end
                end
                if (best < 0 || s < best) begin
                    best = s; by = py; bx = px;
                end
            end
        end
        exp_res = {16'(best), 3'b000, 5'(by - 8), 3'b000, 5'(bx - 8)};
    endtask

    // R6/R7/R8: start, compare status on every clock, then read the result.
    task automatic run(int restart_at);
        @(negedge clk);
        host_we = 1'b1; host_addr = 9'(CTRL); host_wdata = 32'h1;
        @(negedge clk);
        host_we = 1'b0;
        for (int k = 1; k <= LAT + 2; k++) begin
            @(negedge clk);
            if (k < LAT) check(restart_at > 0 ? "R8" : "R6", host_rdata, 32'h1);
            else         check("R7", host_rdata, 32'h2);
            host_we = (k == restart_at);
        end
        host_we = 1'b0;
        rd(RES, v);
        check("R3", v, exp_res);
    endtask

    initial begin
        rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(CTRL, v); check("R10", v, 32'h0);
        rd(RES, v);  check("R10", v, 32'h0);

        wr(400, 32'hA5C3_1E77);
        wr(401, 32'h0F0F_0F0F);
        rd(400, v); check("R1", v, 32'hA5C3_1E77);
        rd(401, v); check("R1", v, 32'h0F0F_0F0F);

        // Random window, exact copy at py=11, px=3 -> y=+3, x=-5.
        for (int i = 0; i < 961; i++) win[i] = rnd();
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++) blk[r*16+c] = win[(11+r)*31 + 3 + c];
        load_mem(); model(); run(0);
        check("R2", exp_res, 32'h0000_031B);

        // R9: clear-bit control write and result write have no effect.
        wr(CTRL, 32'h0);
        rd(CTRL, v); check("R9", v, 32'h2);
        wr(RES, 32'hFFFF_FFFF);
        rd(RES, v); check("R9", v, exp_res);

        // R5: uniform image, every placement ties -> first one (-8,-8).
        for (int i = 0; i < 961; i++) win[i] = 8'h80;
        for (int i = 0; i < 256; i++) blk[i] = 8'h80;
        load_mem(); model(); run(0);
        check("R5", exp_res, 32'h0000_1818);

        // R11: white block, black window -> maximum score 65280.
        for (int i = 0; i < 961; i++) win[i] = 0;
        for (int i = 0; i < 256; i++) blk[i] = 255;
        load_mem(); model(); run(0);
        check("R11", exp_res, 32'hFF00_1818);

        // R4: bottom-right copy with one-count error, restart attempted mid-run (R8).
        for (int i = 0; i < 961; i++) win[i] = rnd();
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++) blk[r*16+c] = win[(15+r)*31 + 15 + c];
        blk[0] = blk[0] ^ 1;
        load_mem(); model(); run(100);
        check("R4", exp_res, 32'h0001_0707);

        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule